// File: doc/BRIEF.md
# Microcontroller Power-Down Wake Sequencer

This block tracks the low-power state of a small embedded controller CPU and decides how that CPU resumes. The core's instruction decoder sends one strobe for a light sleep and another for a deep sleep. In light sleep the core clock is gated and the oscillator keeps running. In deep sleep the oscillator enable is also dropped. A host write into the controller's input data buffer, or the CPU reset input, wakes the CPU from either depth.

On a wake, the block gives a single-cycle wake pulse together with a resume-action code. The code tells the core to do one of three things: carry on with the next instruction, call the input-buffer-full interrupt routine, or restart at program address 0. A wake from deep sleep, and every reset, first re-enables the oscillator. The core clock then stays gated for a parameterised settle window, so the oscillator can stabilise before any instruction runs. The CPU core, the decoder and the oscillator cell lie outside this block.

Top module: `pwrdn_wake_seq`

## Requirements
- R1: While `rst_i` is high, `core_ce_o` is 0, `osc_en_o` is 1 and `wake_o` is 0. After the last cycle with `rst_i` high, `core_ce_o` stays 0 for max(SETTLE_TICKS,1) further cycles. It then rises together with a wake pulse that carries resume code 3 (restart at address 0).
- R2: When the CPU is running, a light-sleep strobe (`halt_i`) makes `core_ce_o` 0 from the next cycle, and `osc_en_o` stays 1.
- R3: When the CPU is running, a deep-sleep strobe (`stop_i`) makes both `core_ce_o` and `osc_en_o` 0 from the next cycle. If both strobes arrive in the same cycle, deep sleep is taken.
- R4: In light sleep, a host write (`host_wr_i`) makes `core_ce_o` 1 in the next cycle, together with a wake pulse. The resume code is 2 (call interrupt routine) if `ibf_ie_i` is 1 in the write cycle, and 1 (next instruction) otherwise.
- R5: In deep sleep, a host write makes `osc_en_o` 1 in the next cycle. `core_ce_o` stays 0 for max(SETTLE_TICKS,1) cycles after that, then rises with a wake pulse. The code is 2 or 1, chosen by `ibf_ie_i` as it stood in the write cycle.
- R6: Reset has priority over a host write in the same cycle, in every state. The result is the restart path of R1, with code 3.
- R7: `wake_o` is high for exactly one cycle. `resume_o` is non-zero only while `wake_o` is high, and it is 0 in every other cycle.
- R8: A host write has no effect on the outputs in two cases: while `core_ce_o` is 1, and while the settle window is running. In the settle window, the wake timing and the resume code are unchanged.
- R9: `core_ce_o` rises only in a cycle in which `wake_o` is high, and `osc_en_o` falls only after a deep-sleep strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the settle window counts its cycles |
| rst_i | input | 1 | CPU reset, synchronous, active high; also a wake source |
| halt_i | input | 1 | Light-sleep strobe from instruction decode |
| stop_i | input | 1 | Deep-sleep strobe from instruction decode |
| host_wr_i | input | 1 | Strobe: host wrote a byte into the input data buffer |
| ibf_ie_i | input | 1 | Input-buffer-full interrupt enable |
| core_ce_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator driver enable |
| wake_o | output | 1 | One-cycle wake pulse |
| resume_o | output | 2 | Resume action: 0 none, 1 next instruction, 2 call interrupt, 3 restart at 0 |

## Verification
Two wake causes can land in the same cycle: a host write into the input buffer and a reset. Both the directed cases and the random mix drive the two together, in light sleep and in deep sleep. The bench then expects the restart path: the full settle window, then code 3. It does not expect the short light-sleep wake path or a write-derived code. A second collision is a host write during the settle window of a deep-sleep wake. Here the bench expects the pulse at the unchanged cycle with the code latched at the first write.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_LIGHT  = 2'd1,
      ST_DEEP   = 2'd2,
      ST_SETTLE = 2'd3
   } pwd_state_t;

   typedef enum logic [1:0] {
      RSM_NONE = 2'd0,
      RSM_NEXT = 2'd1,
      RSM_CALL = 2'd2,
      RSM_ZERO = 2'd3
   } pwd_resume_t;

endpackage

// File: rtl/pwd_settle_timer.sv
module pwd_settle_timer #(
   parameter int TICKS = 1024
) (
   input  logic clk,
   input  logic load_i,
   output logic done_o
);
   localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);

   generate
      if (TICKS < 0) begin : g_bad
         $error("pwd_settle_timer: TICKS must not be negative");
      end

      if (TICKS <= 1) begin : g_short
         // one settle cycle is the floor; no counter needed
         logic unused_tmr;
         assign unused_tmr = clk ^ load_i;
         assign done_o     = 1'b1;
      end else begin : g_count
         localparam logic [CW-1:0] LOAD_V = CW'(TICKS - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (load_i)
               cnt_q <= LOAD_V;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end

         assign done_o = (cnt_q == '0);

         assert_cnt_range_R5: assert property (@(posedge clk)
            disable iff (load_i) cnt_q <= LOAD_V)
            else $error("settle counter left its range");

         assert_reload_R1: assert property (@(posedge clk)
            load_i |=> (cnt_q == LOAD_V))
            else $error("settle counter not reloaded");
      end
   endgenerate

endmodule

// File: rtl/pwd_resume_sel.sv
module pwd_resume_sel
   import pwd_pkg::*;
(
   input  logic        ibf_ie_i,
   output pwd_resume_t wr_action_o
);
   // a host-write wake calls the interrupt only when it is enabled
   assign wr_action_o = ibf_ie_i ? RSM_CALL : RSM_NEXT;

endmodule

// File: rtl/pwrdn_wake_seq.sv
module pwrdn_wake_seq
   import pwd_pkg::*;
#(
   parameter int SETTLE_TICKS = 1024
) (
   input  logic       clk,
   input  logic       rst_i,
   input  logic       halt_i,
   input  logic       stop_i,
   input  logic       host_wr_i,
   input  logic       ibf_ie_i,
   output logic       core_ce_o,
   output logic       osc_en_o,
   output logic       wake_o,
   output logic [1:0] resume_o
);
   generate
      if (SETTLE_TICKS < 0 || SETTLE_TICKS > (1 << 24)) begin : g_chk
         $error("pwrdn_wake_seq: SETTLE_TICKS out of range");
      end
   endgenerate

   pwd_state_t  state_q, state_n;
   pwd_resume_t cause_q, cause_n;
   pwd_resume_t act_n, wr_action;
   logic        wake_n;
   logic        tmr_load, tmr_done;

   pwd_resume_sel u_sel (
      .ibf_ie_i    (ibf_ie_i),
      .wr_action_o (wr_action)
   );

   // counter is held loaded everywhere except inside the settle window
   assign tmr_load = rst_i || (state_q != ST_SETTLE);

   pwd_settle_timer #(.TICKS(SETTLE_TICKS)) u_tmr (
      .clk    (clk),
      .load_i (tmr_load),
      .done_o (tmr_done)
   );

   always_comb begin
      state_n = state_q;
      cause_n = cause_q;
      wake_n  = 1'b0;
      act_n   = RSM_NONE;
      if (rst_i) begin
         state_n = ST_SETTLE;
         cause_n = RSM_ZERO;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (stop_i)      state_n = ST_DEEP;
               else if (halt_i) state_n = ST_LIGHT;
            end
            ST_LIGHT: begin
               if (host_wr_i) begin
                  state_n = ST_RUN;
                  wake_n  = 1'b1;
                  act_n   = wr_action;
               end
            end
            ST_DEEP: begin
               if (host_wr_i) begin
                  state_n = ST_SETTLE;
                  cause_n = wr_action;
               end
            end
            ST_SETTLE: begin
               if (tmr_done) begin
                  state_n = ST_RUN;
                  wake_n  = 1'b1;
                  act_n   = cause_q;
               end
            end
            default: state_n = ST_SETTLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      state_q  <= state_n;
      cause_q  <= cause_n;
      wake_o   <= wake_n;
      resume_o <= act_n;
   end

   assign core_ce_o = (state_q == ST_RUN);
   assign osc_en_o  = (state_q != ST_DEEP);

   // ---------------- assertions ----------------
   assert_rst_gates_R1: assert property (@(posedge clk)
      rst_i |=> (!core_ce_o && osc_en_o && !wake_o))
      else $error("reset did not gate the core");

   assert_osc_needs_gate_R3: assert property (@(posedge clk) disable iff (rst_i)
      !osc_en_o |-> !core_ce_o)
      else $error("core running with oscillator off");

   assert_light_keeps_osc_R2: assert property (@(posedge clk) disable iff (rst_i)
      (core_ce_o && halt_i && !stop_i) |=> (osc_en_o && !core_ce_o))
      else $error("light sleep entry wrong");

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst_i)
      wake_o |=> !wake_o)
      else $error("wake pulse longer than one cycle");

   assert_code_with_pulse_R7: assert property (@(posedge clk) disable iff (rst_i)
      (wake_o == (resume_o != 2'd0)))
      else $error("resume code outside wake pulse");

   assert_awake_write_R8: assert property (@(posedge clk) disable iff (rst_i)
      (core_ce_o && host_wr_i) |=> !wake_o)
      else $error("host write while awake woke the core");

   assert_ce_rise_R9: assert property (@(posedge clk) disable iff (rst_i)
      $rose(core_ce_o) |-> wake_o)
      else $error("core clock enabled without wake");

   assert_osc_fall_R9: assert property (@(posedge clk) disable iff (rst_i)
      $fell(osc_en_o) |-> $past(stop_i))
      else $error("oscillator dropped without deep-sleep strobe");

   assert_pulse_enables_R4: assert property (@(posedge clk) disable iff (rst_i)
      wake_o |-> core_ce_o)
      else $error("wake pulse with core gated");

endmodule

// File: tb/pwrdn_wake_seq_test.sv
`timescale 1ns/1ps
module pwrdn_wake_seq_test;
   localparam int N = 12;

   logic clk = 1'b0;
   logic rst_i = 1'b1, halt_i = 1'b0, stop_i = 1'b0, host_wr_i = 1'b0, ibf_ie_i = 1'b0;
   logic core_ce_o, osc_en_o, wake_o;
   logic [1:0] resume_o;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;   // 50 MHz

   pwrdn_wake_seq #(.SETTLE_TICKS(N)) uut (
      .clk(clk), .rst_i(rst_i), .halt_i(halt_i), .stop_i(stop_i),
      .host_wr_i(host_wr_i), .ibf_ie_i(ibf_ie_i),
      .core_ce_o(core_ce_o), .osc_en_o(osc_en_o),
      .wake_o(wake_o), .resume_o(resume_o));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // expected resume code: 3 restart, 2 call, 1 next
   function automatic int exp_code(input bit by_rst, input bit ie);
      if (by_rst) return 3;
      return ie ? 2 : 1;
   endfunction

   // ticks from the wake-stimulus cycle until the pulse is seen
   function automatic int exp_lat(input bit deep, input bit by_rst);
      int s;
      s = (N < 1) ? 1 : N;
      if (!deep && !by_rst) return 1;
      return 1 + s;
   endfunction

   // wait for the pulse, checking gating meanwhile; returns ticks counted
   task automatic wait_wake(output int lat, input bit extra_wr);
      lat = 1;
      while (!wake_o && lat < 3 * N + 4) begin
         chk("R5 settle osc on", osc_en_o, 1);
         chk("R5 settle core gated", core_ce_o, 0);
         host_wr_i = extra_wr ? 1'($urandom_range(0, 1)) : 1'b0;
         ibf_ie_i  = 1'($urandom_range(0, 1));
         tick();
         lat++;
      end
      host_wr_i = 1'b0;
   endtask

   task automatic scenario(input bit deep, input int cause, input bit ie,
                           input int idle, input bit both_strobes);
      int lat;
      bit by_rst;
      by_rst = (cause != 0);
      // enter sleep from run
      if (deep) begin stop_i = 1'b1; halt_i = both_strobes; end
      else halt_i = 1'b1;
      tick();
      stop_i = 1'b0; halt_i = 1'b0;
      chk(deep ? "R3 deep core gated" : "R2 light core gated", core_ce_o, 0);
      chk(deep ? "R3 deep osc off" : "R2 light osc on", osc_en_o, deep ? 0 : 1);
      for (int i = 0; i < idle; i++) begin
         ibf_ie_i = 1'($urandom_range(0, 1));
         tick();
      end
      chk("R7 no pulse while asleep", wake_o, 0);
      // wake stimulus: 0 write, 1 reset, 2 both (R6)
      host_wr_i = (cause != 1);
      rst_i     = (cause != 0);
      ibf_ie_i  = ie;
      tick();
      rst_i = 1'b0; host_wr_i = 1'b0;
      ibf_ie_i = ~ie;   // later enable changes must not alter the code
      if (by_rst)
         wait_wake(lat, 1'b1);
      else if (deep)
         wait_wake(lat, 1'b1);   // R8: writes in the settle window ignored
      else
         lat = wake_o ? 1 : 99;
      chk(by_rst ? (cause == 2 ? "R6 collision latency" : "R1 reset latency")
                 : (deep ? "R5 deep latency" : "R4 light latency"),
          lat, exp_lat(deep, by_rst));
      chk(by_rst ? "R6 restart code" : (deep ? "R5 write code" : "R4 write code"),
          resume_o, exp_code(by_rst, ie));
      chk("R9 core on with pulse", core_ce_o, 1);
      tick();
      chk("R7 pulse one cycle", wake_o, 0);
      chk("R7 code cleared", resume_o, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      int lat;
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (3) tick();
      chk("R1 reset core gated", core_ce_o, 0);
      chk("R1 reset osc on", osc_en_o, 1);
      chk("R1 reset no pulse", wake_o, 0);
      host_wr_i = 1'b1;
      tick();
      rst_i = 1'b0; host_wr_i = 1'b0;
      wait_wake(lat, 1'b0);
      chk("R1 release latency", lat, 1 + N);
      chk("R1 restart code", resume_o, 3);
      tick();
      chk("R7 pulse one cycle", wake_o, 0);

      // R8: writes while awake
      for (int i = 0; i < 4; i++) begin
         host_wr_i = 1'b1; ibf_ie_i = 1'(i);
         tick();
         chk("R8 awake write no pulse", wake_o, 0);
         chk("R8 awake write core on", core_ce_o, 1);
      end
      host_wr_i = 1'b0;

      // directed corners
      scenario(1'b0, 0, 1'b1, 2, 1'b0);  // R4 call
      scenario(1'b0, 0, 1'b0, 0, 1'b0);  // R4 next
      scenario(1'b1, 0, 1'b1, 3, 1'b1);  // R3 both strobes, R5 call
      scenario(1'b1, 0, 1'b0, 1, 1'b0);  // R5 next
      scenario(1'b0, 2, 1'b1, 1, 1'b0);  // R6 light collision
      scenario(1'b1, 2, 1'b1, 2, 1'b0);  // R6 deep collision
      scenario(1'b1, 1, 1'b0, 0, 1'b0);  // R1 reset from deep

      // constrained random mix
      for (int k = 0; k < 60; k++) begin
         scenario(1'($urandom_range(0, 1)), int'($urandom_range(0, 2)),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 6)),
                  1'($urandom_range(0, 1)));
         repeat (int'($urandom_range(0, 3))) tick();
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule